// File: doc/BRIEF.md
# Three-Axis Remapped Index Sequencer

This block generates a stream of element indices for a vector unit. The indices follow a three-level nested loop, so a flat element count can be turned into matrix-style access patterns: transposed walks, reversed rows, or a plane folded away. Software writes a 32-bit shape word that sets three axis sizes, a slot ordering code, per-axis reversal, a slot-drop selector and a small additive offset. A load pulse latches the word and restarts the walk. After that, each step pulse yields one index on the next cycle.

The three loop counters are routed into three ordered slots by the ordering code. The index is built as a mixed-radix number: slot 0 is least significant, and each kept slot's counter is weighted by the product of the sizes of the kept slots below it. The walk never ends. When the outermost axis finishes, it wraps back to its first point. Only the matrix mode is implemented, so the two top bits of the word are carried but never read.

Top module: `remap3d_gen`

## Requirements
- R1: Shape word field positions are as follows. Bits [31:30] hold the mode. Bits [29:28] hold the skip code and bits [27:24] the offset. Bit 23 reverses z, bit 22 reverses y and bit 21 reverses x. Bits [20:18] hold the ordering code. Bits [17:12], [11:6] and [5:0] hold the z, y and x sizes.
- R2: While rst_i is high and on the cycle after it falls, vld_o is 0 and idx_o is 0. The latched word resets to zero, so steps taken before any load produce index 0.
- R3: A step is accepted when step_i is high and load_i is low. One cycle after an accepted step, vld_o is 1 and idx_o carries the new index. In every other case vld_o is 0 one cycle later.
- R4: idx_o keeps its value on every cycle that follows a cycle with no accepted step.
- R5: The walk advances x on every step. y advances when x wraps, and z advances when y wraps. The output sequence repeats with a period equal to the product of the three sizes and never stops.
- R6: An axis with its reverse bit set counts from its size minus one down to 0. Otherwise it counts up from 0.
- R7: The ordering code gives the axes (0=x, 1=y, 2=z) placed in slots 0, 1 and 2. The codes map as 000→(x,y,z), 001→(x,z,y), 010→(y,x,z), 011→(y,z,x), 100→(z,x,y) and 101→(z,y,x). Codes 110 and 111 act as 000.
- R8: The skip code removes one slot from the index. Code 01 removes slot 0, 10 removes slot 1, 11 removes slot 2, and 00 keeps all three slots.
- R9: The index is built from the kept slots, taken in slot order with a weight that starts at 1. Each kept slot adds its counter times the current weight, and the weight is then multiplied by that slot's size.
- R10: The 4-bit offset is added to the index. Every valid index lies in [offset, offset + product of sizes).
- R11: A size field of 0 behaves as size 1.
- R12: A load restarts every axis at its first point using the new word. vld_o is 0 on the cycle after a load, even when step_i was high with it, and the next accepted step yields the new word's first index.
- R13: The mode bits have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Latch shape_i and restart the walk |
| shape_i | input | 32 | Shape configuration word |
| step_i | input | 1 | Request the next index |
| idx_o | output | 19 | Remapped element index |
| vld_o | output | 1 | idx_o was updated by the previous cycle's step |

## Verification
Each result comes out of a single register stage. The index and valid flag for an accepted step appear one cycle after that step, and the cycle after a load always shows valid low. The bench drives every input on the falling edge and samples on the next falling edge, so each output is read exactly one register stage after its cause. Idle cycles inserted between steps are sampled the same way to confirm that valid drops and the index holds. The expected index for the n-th step after a load comes from dividing n by the axis sizes, not from counting, so wrap behaviour is checked across at least two full periods for every ordering, skip and reversal code.

// File: rtl/remap3d_pkg.sv
package remap3d_pkg;

    parameter int WORD_W = 32;
    parameter int NDIM   = 3;
    parameter int DIM_W  = 6;
    parameter int PERM_W = 3;
    parameter int OFF_W  = 4;
    parameter int SKIP_W = 2;

    localparam int PERM_LSB = NDIM * DIM_W;
    localparam int INV_LSB  = PERM_LSB + PERM_W;
    localparam int OFF_LSB  = INV_LSB + NDIM;
    localparam int SKIP_LSB = OFF_LSB + OFF_W;
    localparam int CFG_W    = SKIP_LSB + SKIP_W;
    localparam int IDX_W    = NDIM * DIM_W + 1;
    localparam int SEL_W    = $clog2(NDIM);

    typedef logic [DIM_W-1:0]   dim_t;
    typedef dim_t [NDIM-1:0]    dim_vec_t;
    typedef logic [SEL_W-1:0]   axis_sel_t;
    typedef axis_sel_t [NDIM-1:0] order_t;

    typedef struct packed {
        dim_vec_t           size;
        logic [NDIM-1:0]    rev;
        order_t             order;
        logic [NDIM-1:0]    keep;
        logic [OFF_W-1:0]   offset;
    } shape_cfg_t;

    typedef struct packed {
        logic [CFG_W-1:0]   shape;
        logic [IDX_W-1:0]   idx;
        logic               vld;
    } gen_state_t;

    // slot -> axis assignment for each ordering code
    function automatic order_t slot_order(input logic [PERM_W-1:0] code);
        order_t o;
        case (code)
            3'b001:  begin o[0] = 2'd0; o[1] = 2'd2; o[2] = 2'd1; end
            3'b010:  begin o[0] = 2'd1; o[1] = 2'd0; o[2] = 2'd2; end
            3'b011:  begin o[0] = 2'd1; o[1] = 2'd2; o[2] = 2'd0; end
            3'b100:  begin o[0] = 2'd2; o[1] = 2'd0; o[2] = 2'd1; end
            3'b101:  begin o[0] = 2'd2; o[1] = 2'd1; o[2] = 2'd0; end
            default: begin o[0] = 2'd0; o[1] = 2'd1; o[2] = 2'd2; end
        endcase
        return o;
    endfunction

    // bit s set means slot s contributes to the index
    function automatic logic [NDIM-1:0] slot_keep(input logic [SKIP_W-1:0] code);
        case (code)
            2'b01:   return 3'b110;
            2'b10:   return 3'b101;
            2'b11:   return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/remap3d_shape_dec.sv
module remap3d_shape_dec
    import remap3d_pkg::*;
(
    input  logic [CFG_W-1:0] word_i,
    output shape_cfg_t       cfg_o
);

    dim_vec_t size_eff;

    generate
        for (genvar a = 0; a < NDIM; a++) begin : g_axis
            dim_t raw;
            assign raw         = word_i[a*DIM_W +: DIM_W];
            // an empty axis still advances: treat it as one point
            assign size_eff[a] = (raw == '0) ? DIM_W'(1) : raw;
        end
    endgenerate

    always_comb begin
        cfg_o        = '0;
        cfg_o.size   = size_eff;
        cfg_o.rev    = word_i[INV_LSB +: NDIM];
        cfg_o.order  = slot_order(word_i[PERM_LSB +: PERM_W]);
        cfg_o.keep   = slot_keep(word_i[SKIP_LSB +: SKIP_W]);
        cfg_o.offset = word_i[OFF_LSB +: OFF_W];
    end

endmodule

// File: rtl/remap3d_axis_ctr.sv
module remap3d_axis_ctr
    import remap3d_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic adv_i,
    input  dim_t size_i,
    input  logic rev_i,
    output dim_t cnt_o,
    output logic last_o
);

    dim_t cnt_d, cnt_q;
    dim_t first_pt;
    dim_t final_pt;

    assign first_pt = rev_i ? (size_i - DIM_W'(1)) : '0;
    assign final_pt = rev_i ? '0 : (size_i - DIM_W'(1));
    assign last_o   = (cnt_q == final_pt);
    assign cnt_o    = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = first_pt;
        end else if (adv_i) begin
            if (last_o) begin
                cnt_d = first_pt;
            end else if (rev_i) begin
                cnt_d = cnt_q - DIM_W'(1);
            end else begin
                cnt_d = cnt_q + DIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/remap3d_index_calc.sv
module remap3d_index_calc
    import remap3d_pkg::*;
(
    input  dim_vec_t         cnt_i,
    input  shape_cfg_t       cfg_i,
    output logic [IDX_W-1:0] idx_o
);

    dim_vec_t slot_cnt;
    dim_vec_t slot_sz;

    generate
        for (genvar s = 0; s < NDIM; s++) begin : g_slot
            axis_sel_t sel;
            assign sel = cfg_i.order[s];
            always_comb begin
                case (sel)
                    2'd1:    begin slot_cnt[s] = cnt_i[1]; slot_sz[s] = cfg_i.size[1]; end
                    2'd2:    begin slot_cnt[s] = cnt_i[2]; slot_sz[s] = cfg_i.size[2]; end
                    default: begin slot_cnt[s] = cnt_i[0]; slot_sz[s] = cfg_i.size[0]; end
                endcase
            end
        end
    endgenerate

    always_comb begin
        logic [IDX_W-1:0] acc;
        logic [IDX_W-1:0] weight;
        acc    = '0;
        weight = IDX_W'(1);
        for (int s = 0; s < NDIM; s++) begin
            if (cfg_i.keep[s]) begin
                acc    = acc + IDX_W'(slot_cnt[s]) * weight;
                weight = weight * IDX_W'(slot_sz[s]);
            end
        end
        idx_o = acc + IDX_W'(cfg_i.offset);
    end

endmodule

// File: rtl/remap3d_gen.sv
module remap3d_gen
    import remap3d_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] shape_i,
    input  logic              step_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              vld_o
);

    gen_state_t st_d, st_q;

    logic             accept;
    logic [CFG_W-1:0] cfg_word;
    shape_cfg_t       cfg;
    dim_vec_t         cnt;
    logic [NDIM-1:0]  last;
    logic [NDIM-1:0]  adv;
    logic [IDX_W-1:0] idx_next;
    logic             mode_unused;
    logic             wrap_unused;

    assign mode_unused = ^shape_i[WORD_W-1:CFG_W];
    assign wrap_unused = last[NDIM-1];

    assign accept   = step_i && !load_i;
    // a load restarts the axes from the incoming word, not the stored one
    assign cfg_word = load_i ? shape_i[CFG_W-1:0] : st_q.shape;

    remap3d_shape_dec u_dec (
        .word_i (cfg_word),
        .cfg_o  (cfg)
    );

    assign adv[0] = accept;
    generate
        for (genvar a = 1; a < NDIM; a++) begin : g_chain
            assign adv[a] = adv[a-1] && last[a-1];
        end
        for (genvar a = 0; a < NDIM; a++) begin : g_ctr
            remap3d_axis_ctr u_ctr (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .clr_i  (load_i),
                .adv_i  (adv[a]),
                .size_i (cfg.size[a]),
                .rev_i  (cfg.rev[a]),
                .cnt_o  (cnt[a]),
                .last_o (last[a])
            );
        end
    endgenerate

    remap3d_index_calc u_calc (
        .cnt_i (cnt),
        .cfg_i (cfg),
        .idx_o (idx_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = accept;
        if (load_i) begin
            st_d.shape = shape_i[CFG_W-1:0];
        end
        if (accept) begin
            st_d.idx = idx_next;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/remap3d_chk.sv
module remap3d_chk
    import remap3d_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              load_i,
    input logic [WORD_W-1:0] shape_i,
    input logic              step_i,
    input logic [IDX_W-1:0]  idx_o,
    input logic              vld_o
);

    localparam int CNT_W = IDX_W + 1;

    dim_t             xs_q, ys_q, zs_q;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] seen_q;
    logic [IDX_W-1:0] first_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] lo_bound;
    logic [CNT_W-1:0] hi_bound;
    logic             chk_unused;

    assign chk_unused = ^{shape_i[WORD_W-1:OFF_LSB+OFF_W], shape_i[OFF_LSB-1:PERM_LSB]};

    function automatic logic [CNT_W-1:0] eff(input dim_t v);
        return (v == '0) ? CNT_W'(1) : CNT_W'(v);
    endfunction

    assign period   = eff(xs_q) * eff(ys_q) * eff(zs_q);
    assign lo_bound = CNT_W'(off_q);
    assign hi_bound = lo_bound + period;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            xs_q    <= '0;
            ys_q    <= '0;
            zs_q    <= '0;
            off_q   <= '0;
            seen_q  <= '0;
            first_q <= '0;
        end else if (load_i) begin
            xs_q    <= shape_i[0 +: DIM_W];
            ys_q    <= shape_i[DIM_W +: DIM_W];
            zs_q    <= shape_i[2*DIM_W +: DIM_W];
            off_q   <= shape_i[OFF_LSB +: OFF_W];
            seen_q  <= '0;
        end else if (vld_o) begin
            if (seen_q == '0) begin
                first_q <= idx_o;
            end
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    // R3
    step_gives_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !load_i) |=> vld_o);

    // R3
    no_step_no_vld_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(step_i && !load_i) |=> !vld_o);

    // R4
    idx_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(step_i && !load_i) |=> $stable(idx_o));

    // R10
    idx_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |-> ((CNT_W'(idx_o) >= lo_bound) && (CNT_W'(idx_o) < hi_bound)));

    // R5
    wrap_period_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_o && (seen_q == period)) |-> (idx_o == first_q));

endmodule

bind remap3d_gen remap3d_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load_i),
    .shape_i (shape_i),
    .step_i  (step_i),
    .idx_o   (idx_o),
    .vld_o   (vld_o)
);

// File: tb/remap3d_gen_tb.sv
`timescale 1ns/1ps
module remap3d_gen_tb;

    logic        clk = 1'b0;
    logic        rst_i;
    logic        load_i;
    logic [31:0] shape_i;
    logic        step_i;
    logic [18:0] idx_o;
    logic        vld_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    remap3d_gen u_dut (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .load_i  (load_i),
        .shape_i (shape_i),
        .step_i  (step_i),
        .idx_o   (idx_o),
        .vld_o   (vld_o)
    );

    // R1 field layout
    function automatic logic [31:0] mk(input int mode, input int skip, input int off,
                                       input int rev, input int perm,
                                       input int zs, input int ys, input int xs);
        return {mode[1:0], skip[1:0], off[3:0], rev[2:0], perm[2:0],
                zs[5:0], ys[5:0], xs[5:0]};
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected index of the n-th step after a load (R5..R11)
    function automatic int ref_idx(input logic [31:0] w, input int n);
        int sz[3];
        int pos[3];
        int c[3];
        int ord[3];
        int keep;
        int acc;
        int wt;
        sz[0] = eff(int'(w[5:0]));
        sz[1] = eff(int'(w[11:6]));
        sz[2] = eff(int'(w[17:12]));
        pos[0] = n % sz[0];
        pos[1] = (n / sz[0]) % sz[1];
        pos[2] = (n / (sz[0] * sz[1])) % sz[2];
        for (int a = 0; a < 3; a++)
            c[a] = w[21 + a] ? (sz[a] - 1 - pos[a]) : pos[a];
        case (w[20:18])
            3'b001:  begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
            3'b010:  begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
            3'b011:  begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
            3'b100:  begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
            3'b101:  begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
            default: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
        endcase
        case (w[29:28])
            2'b01:   keep = 3'b110;
            2'b10:   keep = 3'b101;
            2'b11:   keep = 3'b011;
            default: keep = 3'b111;
        endcase
        acc = 0;
        wt  = 1;
        for (int s = 0; s < 3; s++) begin
            if (keep[s]) begin
                acc = acc + c[ord[s]] * wt;
                wt  = wt * sz[ord[s]];
            end
        end
        return acc + int'(w[27:24]);
    endfunction

    function automatic int period_of(input logic [31:0] w);
        return eff(int'(w[5:0])) * eff(int'(w[11:6])) * eff(int'(w[17:12]));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] w);
        load_i  = 1'b1;
        shape_i = w;
        step_i  = 1'b0;
        @(negedge clk);
        load_i = 1'b0;
        chk("R12 vld after load", int'(vld_o), 0);
    endtask

    task automatic step_once(input logic [31:0] w, input int n, input string req);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        chk("R3 vld after step", int'(vld_o), 1);
        chk(req, int'(idx_o), ref_idx(w, n));
    endtask

    task automatic idle_once();
        int prev;
        prev = int'(idx_o);
        @(negedge clk);
        chk("R3 vld idle", int'(vld_o), 0);
        chk("R4 idx hold", int'(idx_o), prev);
    endtask

    task automatic run_seq(input logic [31:0] w, input int nsteps, input bit gaps, input string req);
        do_load(w);
        for (int n = 0; n < nsteps; n++) begin
            if (gaps && ($urandom % 4 == 0)) idle_once();
            step_once(w, n, req);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h1A2B3C4D));
        rst_i = 1'b1; load_i = 1'b0; step_i = 1'b0; shape_i = '0;
        repeat (4) @(negedge clk);
        chk("R2 vld in reset", int'(vld_o), 0);
        chk("R2 idx in reset", int'(idx_o), 0);
        rst_i = 1'b0;
        @(negedge clk);
        chk("R2 vld after reset", int'(vld_o), 0);
        chk("R2 idx after reset", int'(idx_o), 0);
        step_once(32'h0, 0, "R2 idx before load");
        step_once(32'h0, 1, "R2 idx before load");
        idle_once();

        // R5 small demo walk, several wraps
        w = mk(0, 0, 0, 0, 3'b010, 1, 2, 3);
        run_seq(w, 3 * period_of(w), 1'b1, "R5 demo walk");

        // R7 every ordering code, including the two spare codes
        for (int p = 0; p < 8; p++) begin
            w = mk(0, 0, 2, 0, p, 2, 4, 3);
            run_seq(w, 2 * period_of(w) + 1, 1'b0, "R7 ordering");
        end

        // R8 every skip code
        for (int k = 0; k < 4; k++) begin
            w = mk(0, k, 0, 0, 3'b011, 3, 2, 4);
            run_seq(w, 2 * period_of(w) + 1, 1'b0, "R8 skip");
        end

        // R6 every reversal combination
        for (int r = 0; r < 8; r++) begin
            w = mk(0, 0, 0, r, 3'b100, 2, 3, 4);
            run_seq(w, 2 * period_of(w) + 1, 1'b1, "R6 reversal");
        end

        // R9 weighting with large sizes and a dropped middle slot
        w = mk(0, 2, 15, 3'b101, 3'b101, 5, 63, 40);
        run_seq(w, 130, 1'b0, "R9 weighting");

        // R11 zero sizes, R10 offset
        w = mk(0, 0, 9, 0, 0, 0, 4, 0);
        run_seq(w, 2 * period_of(w) + 1, 1'b0, "R11 zero size");
        w = mk(0, 0, 0, 3'b111, 0, 0, 0, 0);
        run_seq(w, 3, 1'b0, "R11 all zero");

        // R13 mode bits ignored
        w = mk(3, 1, 6, 3'b010, 3'b001, 2, 3, 2);
        run_seq(w, 2 * period_of(w) + 1, 1'b0, "R13 mode");

        // R12 reload mid-walk, then load together with step
        w = mk(0, 0, 0, 0, 0, 3, 3, 3);
        run_seq(w, 5, 1'b0, "R12 before reload");
        w = mk(0, 0, 1, 3'b001, 3'b011, 2, 2, 5);
        run_seq(w, period_of(w) + 2, 1'b0, "R12 after reload");
        step_once(w, period_of(w) + 2, "R12 continue");
        load_i = 1'b1; step_i = 1'b1; shape_i = mk(0, 3, 4, 3'b100, 3'b000, 3, 2, 2);
        w = shape_i;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
        chk("R12 load beats step", int'(vld_o), 0);
        for (int n = 0; n < 2 * period_of(w) + 1; n++) step_once(w, n, "R12 restart");

        // random shapes
        for (int t = 0; t < 40; t++) begin
            w = mk($urandom % 4, $urandom % 4, $urandom % 16, $urandom % 8, $urandom % 8,
                   $urandom % 6, $urandom % 6, $urandom % 6);
            run_seq(w, 2 * period_of(w) + 1, 1'b1, "R9 random shape");
        end

        idle_once();
        done = 1;
        finish_run();
    end

endmodule